// File: doc/BRIEF.md
# Log-depth unsigned greater-than comparator

This block decides whether one unsigned operand is strictly larger than another, with no clock and no state. Each bit position gets a small cell that classifies that position as equal, lower or higher. The bit verdicts are then merged pairwise in a balanced tree until one verdict remains. Every merge keeps the verdict of its more-significant half unless that half is equal. If the more-significant half is equal, the merge passes on the verdict of its less-significant half. The depth therefore grows with the logarithm of the operand width, not linearly with it.

The width is a parameter and must be a power of two of at least 2. A wider datapath uses the same leaf cell and the same merge node, only more levels of them. The single output is high only for a strict "greater than". It is low both for equal operands and for a smaller first operand.

Top module: `mag_tree_cmp`

## Requirements
- R1: `gt_out` is 1 whenever `a_in` is greater than `b_in`, both read as unsigned integers.
- R2: `gt_out` is 0 whenever `a_in` equals `b_in`.
- R3: `gt_out` is 0 whenever `a_in` is less than `b_in`.
- R4: Bit WIDTH-1 is the most significant bit of both operands. When the operands differ there, that bit alone decides `gt_out`, whatever the lower bits hold.
- R5: When all bits above the lowest differing bit are equal, the lowest differing bit decides `gt_out`, down to bit 0.
- R6: The same structure is correct for any power-of-two WIDTH of at least 2. It has WIDTH leaf cells, WIDTH-1 merge nodes and log2(WIDTH) merge levels. The result is exercised at WIDTH 8 and WIDTH 16.
- R7: A leaf cell emits a two-bit code {gt, defer}: equal bits give {0,1}, a lower `a_in` bit gives {0,0}, and a higher `a_in` bit gives {1,0}. The code {1,1} never appears anywhere in the tree.
- R8: A merge node forwards its more-significant input code when that code's defer bit is 0. Otherwise it forwards its less-significant input code. When the two halves disagree, the upper half therefore wins.
- R9: `gt_out` is the gt bit of the code at the root of the tree.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | WIDTH | First operand, unsigned, bit WIDTH-1 most significant |
| b_in | input | WIDTH | Second operand, unsigned, bit WIDTH-1 most significant |
| gt_out | output | 1 | High when a_in is strictly greater than b_in |

## Verification
Two merge inputs can both carry a decided verdict at the same moment, with the upper half saying one thing and the lower half the opposite. The selection logic must then let the upper verdict through and drop the lower one. This case is provoked by operand pairs whose high and low halves order in opposite directions, such as 0xF0 against 0x0F and the reverse. It is also covered by the full sweep of all 65,536 pairs at width 8, with 16-bit random and corner pairs on top. The result is judged against the bench's own integer comparison of the two operands.

// File: rtl/magcmp_pkg.sv
package magcmp_pkg;

    // Two-bit verdict carried through the tree.
    // gt    : this slice of a_in is larger than the same slice of b_in
    // defer : this slice is equal, so a less-significant slice decides
    typedef struct packed {
        logic gt;
        logic defer;
    } rel_code_t;

    localparam rel_code_t CODE_EQ = '{gt: 1'b0, defer: 1'b1};
    localparam rel_code_t CODE_LT = '{gt: 1'b0, defer: 1'b0};
    localparam rel_code_t CODE_GT = '{gt: 1'b1, defer: 1'b0};

    // Classify one bit position.
    function automatic rel_code_t encode_bit(input logic a_b, input logic b_b);
        rel_code_t r;
        if (a_b == b_b)
            r = CODE_EQ;
        else if (a_b)
            r = CODE_GT;
        else
            r = CODE_LT;
        return r;
    endfunction

    // Stitch two neighbouring verdicts: the upper one rules unless equal.
    function automatic rel_code_t stitch(input rel_code_t hi, input rel_code_t lo);
        return hi.defer ? lo : hi;
    endfunction

    // True when v is a power of two of at least 2.
    function automatic bit width_ok(input int v);
        return (v >= 2) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/mag_leaf_cell.sv
module mag_leaf_cell
    import magcmp_pkg::*;
(
    input  logic      a_bit,
    input  logic      b_bit,
    output rel_code_t code
);

    always_comb begin
        code = encode_bit(a_bit, b_bit);
    end

    // R7: leaf codes stay inside the three legal values
    always_comb begin
        if (!$isunknown({a_bit, b_bit})) begin
            p_leaf_legal_r7: assert (!(code.gt && code.defer))
                else $error("leaf emitted illegal code {1,1}");
            if (code.gt) begin
                p_leaf_gt_r7: assert (a_bit && !b_bit)
                    else $error("leaf claims greater without a=1,b=0");
            end
            if (code.defer) begin
                p_leaf_eq_r7: assert (a_bit == b_bit)
                    else $error("leaf defers on unequal bits");
            end
        end
    end

endmodule

// File: rtl/mag_merge_node.sv
module mag_merge_node
    import magcmp_pkg::*;
(
    input  rel_code_t hi_code,
    input  rel_code_t lo_code,
    output rel_code_t out_code
);

    // 2-bit-wide 2:1 selector steered by the upper half's defer flag
    always_comb begin
        out_code = stitch(hi_code, lo_code);
    end

    always_comb begin
        if (!$isunknown({hi_code, lo_code})) begin
            // R7: no illegal code enters or leaves a merge
            p_merge_legal_r7: assert (!(out_code.gt && out_code.defer))
                else $error("merge produced illegal code {1,1}");
            // R8: a larger result needs the upper half larger, or equal with the lower larger
            if (out_code.gt) begin
                p_gt_source_r8: assert (hi_code.gt || (hi_code.defer && lo_code.gt))
                    else $error("merge asserts gt without a justifying input");
            end
            // R8: an equal result needs both halves equal
            if (out_code.defer) begin
                p_defer_source_r8: assert (hi_code.defer && lo_code.defer)
                    else $error("merge defers while a half is decided");
            end
            // R8: a decided upper half is never overridden
            if (!hi_code.defer) begin
                p_hi_rules_r8: assert (out_code.gt == hi_code.gt && !out_code.defer)
                    else $error("decided upper half was overridden");
            end
        end
    end

endmodule

// File: rtl/mag_tree_cmp.sv
module mag_tree_cmp
    import magcmp_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    output logic             gt_out
);

    localparam int LEVELS = $clog2(WIDTH);

    // R6: only power-of-two widths of at least 2 build a balanced tree
    if (!width_ok(WIDTH)) begin : g_bad_width
        initial $error("mag_tree_cmp: WIDTH must be a power of two >= 2");
    end

    // Level 0 holds WIDTH leaf codes, level s holds WIDTH>>s merged codes.
    // Within a level, index 0 is the most-significant slice.
    for (genvar s = 0; s <= LEVELS; s++) begin : g_lvl
        localparam int COUNT = WIDTH >> s;
        rel_code_t code [COUNT];

        if (s == 0) begin : g_leaves
            for (genvar p = 0; p < COUNT; p++) begin : g_bit
                mag_leaf_cell u_leaf (
                    .a_bit (a_in[WIDTH-1-p]),
                    .b_bit (b_in[WIDTH-1-p]),
                    .code  (code[p])
                );
            end
        end else begin : g_merges
            for (genvar j = 0; j < COUNT; j++) begin : g_node
                mag_merge_node u_merge (
                    .hi_code  (g_lvl[s-1].code[2*j]),
                    .lo_code  (g_lvl[s-1].code[2*j+1]),
                    .out_code (code[j])
                );
            end
        end
    end

    // R9: the answer is the gt bit of the root verdict
    assign gt_out = g_lvl[LEVELS].code[0].gt;

    always_comb begin
        if (!$isunknown({a_in, b_in})) begin
            // R2: equal operands never report greater
            if (a_in == b_in) begin
                p_equal_low_r2: assert (!gt_out)
                    else $error("gt_out high for equal operands");
            end
            // R4: an MSB split forces the answer
            if (a_in[WIDTH-1] != b_in[WIDTH-1]) begin
                p_msb_decides_r4: assert (gt_out == a_in[WIDTH-1])
                    else $error("MSB difference not honoured");
            end
            // R9: an equal root verdict means gt_out is low
            if (g_lvl[LEVELS].code[0].defer) begin
                p_root_defer_r9: assert (!gt_out && a_in == b_in)
                    else $error("root defers but operands differ or gt_out high");
            end
        end
    end

endmodule

// File: tb/mag_tree_cmp_test.sv
module mag_tree_cmp_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;  // 250 MHz

    logic [7:0]  a8,  b8;
    logic [15:0] a16, b16;
    logic        gt8, gt16;

    int tests  = 0;
    int failed = 0;
    bit done   = 1'b0;

    mag_tree_cmp #(.WIDTH(8)) uut (
        .a_in   (a8),
        .b_in   (b8),
        .gt_out (gt8)
    );

    mag_tree_cmp #(.WIDTH(16)) uut16 (
        .a_in   (a16),
        .b_in   (b16),
        .gt_out (gt16)
    );

    task automatic check(input string req, input logic actual, input logic expected,
                         input logic [15:0] a, input logic [15:0] b);
        tests++;
        if (actual !== expected) begin
            failed++;
            $display("FAIL %s a=%0h b=%0h actual=%0b expected=%0b", req, a, b, actual, expected);
        end
    endtask

    function automatic string tag_for(input logic [15:0] a, input logic [15:0] b);
        if (a > b)       return "R1";
        else if (a == b) return "R2";
        else             return "R3";
    endfunction

    // drive on the rising edge, sample at the following falling edge
    task automatic run8(input string req, input logic [7:0] a, input logic [7:0] b);
        @(posedge clk);
        a8 = a;
        b8 = b;
        @(negedge clk);
        check(req, gt8, (a > b) ? 1'b1 : 1'b0, {8'h0, a}, {8'h0, b});
    endtask

    task automatic run16(input string req, input logic [15:0] a, input logic [15:0] b);
        @(posedge clk);
        a16 = a;
        b16 = b;
        @(negedge clk);
        check(req, gt16, (a > b) ? 1'b1 : 1'b0, a, b);
    endtask

    initial begin
        a8 = '0; b8 = '0; a16 = '0; b16 = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state: zero operands, R2
        check("R2", gt8,  1'b0, 16'h0, 16'h0);
        check("R2", gt16, 1'b0, 16'h0, 16'h0);

        // R4: MSB decides against opposite lower bits
        run8("R4", 8'h80, 8'h7F);
        run8("R4", 8'h7F, 8'h80);
        run16("R4", 16'h8000, 16'h7FFF);
        run16("R4", 16'h7FFF, 16'h8000);
        // R5: only the lowest bit differs
        run8("R5", 8'h01, 8'h00);
        run8("R5", 8'h00, 8'h01);
        run16("R5", 16'hA5A5, 16'hA5A4);
        run16("R5", 16'hA5A4, 16'hA5A5);
        // R8: halves disagree, upper half must win
        run8("R8", 8'hF0, 8'h0F);
        run8("R8", 8'h0F, 8'hF0);
        run8("R8", 8'h3C, 8'h2D);
        run16("R8", 16'h1200, 16'h11FF);
        // R7 and R9: all-equal and all-ones extremes
        run8("R7", 8'hFF, 8'hFF);
        run8("R9", 8'hFF, 8'hFE);
        run16("R7", 16'hFFFF, 16'hFFFF);

        // R1 R2 R3: every 8-bit pair
        for (int i = 0; i < 256; i++) begin
            for (int k = 0; k < 256; k++) begin
                run8(tag_for(16'(i), 16'(k)), 8'(i), 8'(k));
            end
        end

        // R6: 16-bit random pairs, some forced to share upper bits
        for (int n = 0; n < 3000; n++) begin
            logic [15:0] ra, rb;
            ra = 16'($urandom);
            rb = 16'($urandom);
            if (n % 3 == 0) rb[15:8] = ra[15:8];
            if (n % 7 == 0) rb = ra;
            run16("R6", ra, rb);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            failed++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, failed);
            $finish;
        end
    end

endmodule